// File: doc/BRIEF.md
# 32-bit PCI Target Interface

This block is the slave side of a 32-bit, 33 MHz PCI attachment. It watches the shared bus for a new address phase and captures address, command and the initialization-select line on the edge that closes that phase. It then decides whether the cycle belongs to it. A cycle belongs to it if it is an I/O cycle that lands inside one of its I/O windows, or a type-0 configuration cycle with the select line high. A claimed cycle is answered with medium-speed DEVSEL and TRDY. The block then moves one 32-bit word per completed data phase across a small internal register port, and it steps the word address on its own during bursts.

The block generates even parity for the data it returns, and it checks parity on the address and on write data. Write-data errors go out on PERR. Address errors are pulled onto the open-drain SERR line. The pads are modelled as separate input, output and output-enable signals, so the module can sit behind any pad ring. The base of each I/O window is supplied from outside as the upper address bits only. The window size is a parameter.

Top module: `pcit_target`

## Requirements
- R1: While reset is low and on the first cycle after it, no bus output is enabled (`tgt_oe`, `ad_oe`, `par_oe` low), `serr_oe` is low, `perr_n` is high and neither register strobe is active.
- R2: A cycle is claimed when its command is I/O read (0010) or I/O write (0011) and address bits [31:IO_WIN_LOG2] equal a window base, or when its command is configuration read (1010) or write (1011) with `idsel` high and address bits [1:0] = 00. In that case `devsel_n` and `trdy_n` go low, with `tgt_oe` high and `stop_n` high, from the second cycle after the address phase until the final transfer.
- R3: Any other command, an I/O address outside every window, or a configuration cycle without `idsel` or with address bits [1:0] other than 00, leaves `tgt_oe` low and produces no register strobe.
- R4: A data phase completes in a cycle where `irdy_n` and `trdy_n` are both low. For a write, that cycle shows `reg_wr` high with `reg_wdata` = AD and `reg_be` = inverted C/BE. `reg_space` is 0 for configuration and k+1 for window k, with the lowest-numbered matching window taking precedence. A cycle with `irdy_n` high is a wait state with no strobe.
- R5: `reg_addr` starts at the captured address and rises by 4 after every completed data phase of a burst.
- R6: During a claimed read, AD is driven with `reg_rdata` for the current `reg_addr` and `reg_rd` marks each completed phase. `par_oe` is high exactly one cycle after each cycle in which AD was driven, and `par_o` then equals the XOR of that AD word and C/BE.
- R7: After a transfer made with `frame_n` high, the next cycle shows `trdy_n` and `devsel_n` high with `tgt_oe` still high. `tgt_oe` is low in the cycle after that.
- R8: If the parity bit presented in the cycle after a completed write phase does not give even parity over that phase's AD and C/BE, `perr_n` is low for one cycle, two cycles after the transfer cycle.
- R9: If the parity bit in the cycle after an address phase does not give even parity over address and command, `serr_oe` is high for one cycle, two cycles after the address phase, and the cycle is not claimed.
- R10: Once a cycle has not been claimed, no address is sampled until `frame_n` and `irdy_n` are both high, even if `frame_n` stays low with a matching address on AD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 32 | AD bus as seen at the pad |
| ad_o | output | 32 | Read data driven to AD |
| ad_oe | output | 1 | AD output enable |
| cbe_n | input | 4 | Command / active-low byte enables |
| par_i | input | 1 | PAR as seen at the pad |
| par_o | output | 1 | Generated PAR for read data |
| par_oe | output | 1 | PAR output enable |
| frame_n | input | 1 | FRAME from the initiator |
| irdy_n | input | 1 | Initiator ready |
| idsel | input | 1 | Configuration select |
| trdy_n | output | 1 | Target ready |
| devsel_n | output | 1 | Device select |
| stop_n | output | 1 | Stop, always driven high |
| tgt_oe | output | 1 | Enable for trdy_n, devsel_n, stop_n |
| perr_n | output | 1 | Data parity error, active low |
| serr_oe | output | 1 | Pull-down enable for open-drain SERR |
| bar_base | input | BAR_CNT*(32-IO_WIN_LOG2) | Upper address bits of each I/O window, window 0 in the low slice |
| reg_addr | output | 32 | Word address of the current data phase |
| reg_space | output | $clog2(BAR_CNT+1) | 0 configuration, k+1 window k |
| reg_wr | output | 1 | Write strobe, one per completed write phase |
| reg_rd | output | 1 | Read strobe, one per completed read phase |
| reg_wdata | output | 32 | Write data |
| reg_be | output | 4 | Active-high byte enables |
| reg_rdata | input | 32 | Read data for reg_addr, same cycle |

## Verification
A decoder or sequencer stuck in the wrong state shows up within two cycles of an address phase. Either `devsel_n` fails to fall in the second cycle, or the block claims a cycle it should ignore. An address counter that drifts is caught on the second phase of any burst, through `reg_addr` and through the read word on AD. A misaligned parity pipeline shows up one cycle late on `par_o`, or as `perr_n`/`serr_oe` pulses in the wrong cycle, and these are compared on every cycle of every transaction. A release path that holds the bus is seen in the two cycles after the final transfer through `tgt_oe`.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECODE,
      ST_DATA,
      ST_TURN,
      ST_WAIT
   } pcit_state_e;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned LANE_N = WORD_W / 8;

   // even-parity bit over a data word and its lane enables
   function automatic logic even_bit(input logic [WORD_W-1:0] d,
                                     input logic [LANE_N-1:0] c);
      return ^{d, c};
   endfunction
endpackage

// File: rtl/pcit_decode.sv
module pcit_decode #(
   parameter int unsigned BAR_CNT     = 2,
   parameter int unsigned IO_WIN_LOG2 = 4,
   localparam int unsigned BASE_W     = 32 - IO_WIN_LOG2,
   localparam int unsigned SPACE_W    = $clog2(BAR_CNT + 1)
) (
   input  logic [BASE_W-1:0]         addr_hi,
   input  logic [1:0]                addr_lo,
   input  logic [2:0]                cmd_hi,
   input  logic                      sel,
   input  logic [BAR_CNT*BASE_W-1:0] bar_base,
   output logic                      hit,
   output logic [SPACE_W-1:0]        space
);
   timeunit 1ns;
   timeprecision 1ps;

   if (BAR_CNT < 1 || BAR_CNT > 6) begin : g_bad_cnt
      $error("pcit_decode: BAR_CNT must be 1..6");
   end
   if (IO_WIN_LOG2 < 2 || IO_WIN_LOG2 > 16) begin : g_bad_win
      $error("pcit_decode: IO_WIN_LOG2 must be 2..16");
   end

   logic [BAR_CNT-1:0] win_hit;
   logic               is_io, is_cfg;

   for (genvar b = 0; b < BAR_CNT; b++) begin : g_win
      assign win_hit[b] = (addr_hi == bar_base[b*BASE_W +: BASE_W]);
   end

   assign is_io  = (cmd_hi == 3'b001);
   assign is_cfg = (cmd_hi == 3'b101) && sel && (addr_lo == 2'b00);

   always_comb begin
      hit   = 1'b0;
      space = '0;
      if (is_cfg) begin
         hit = 1'b1;
      end else if (is_io) begin
         for (int b = BAR_CNT - 1; b >= 0; b--) begin
            if (win_hit[b]) begin
               hit   = 1'b1;
               space = SPACE_W'(b + 1);
            end
         end
      end
   end
endmodule

// File: rtl/pcit_parity.sv
module pcit_parity
   import pcit_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] ad_i,
   input  logic [LANE_N-1:0] cbe_n,
   input  logic              par_i,
   input  logic [WORD_W-1:0] ad_o,
   input  logic              ad_oe,
   input  logic              wr_xfer,
   input  logic              addr_chk,
   input  logic              addr_par,
   output logic              addr_bad,
   output logic              par_o,
   output logic              par_oe,
   output logic              perr_n,
   output logic              serr_oe
);
   timeunit 1ns;
   timeprecision 1ps;

   logic wchk_q, wpar_q;

   assign addr_bad = addr_chk && (addr_par != par_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wchk_q  <= 1'b0;
         wpar_q  <= 1'b0;
         perr_n  <= 1'b1;
         serr_oe <= 1'b0;
         par_o   <= 1'b0;
         par_oe  <= 1'b0;
      end else begin
         wchk_q  <= wr_xfer;
         wpar_q  <= even_bit(ad_i, cbe_n);
         perr_n  <= !(wchk_q && (wpar_q != par_i));
         serr_oe <= addr_bad;
         par_o   <= even_bit(ad_o, cbe_n);
         par_oe  <= ad_oe;
      end
   end

   // R8: a PERR pulse is always traced back to a write transfer two cycles earlier
   p_perr_after_write_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n |-> $past(wr_xfer, 2));
   // R9: SERR is a single-cycle pulse
   p_serr_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |=> !serr_oe);
   // R6: PAR is only driven the cycle after AD was driven
   p_par_follows_ad_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      par_oe |-> $past(ad_oe));
endmodule

// File: rtl/pcit_target.sv
module pcit_target
   import pcit_pkg::*;
#(
   parameter int unsigned BAR_CNT     = 2,
   parameter int unsigned IO_WIN_LOG2 = 4,
   localparam int unsigned BASE_W     = 32 - IO_WIN_LOG2,
   localparam int unsigned SPACE_W    = $clog2(BAR_CNT + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [31:0]               ad_i,
   output logic [31:0]               ad_o,
   output logic                      ad_oe,
   input  logic [3:0]                cbe_n,
   input  logic                      par_i,
   output logic                      par_o,
   output logic                      par_oe,
   input  logic                      frame_n,
   input  logic                      irdy_n,
   input  logic                      idsel,
   output logic                      trdy_n,
   output logic                      devsel_n,
   output logic                      stop_n,
   output logic                      tgt_oe,
   output logic                      perr_n,
   output logic                      serr_oe,
   input  logic [BAR_CNT*BASE_W-1:0] bar_base,
   output logic [31:0]               reg_addr,
   output logic [SPACE_W-1:0]        reg_space,
   output logic                      reg_wr,
   output logic                      reg_rd,
   output logic [31:0]               reg_wdata,
   output logic [3:0]                reg_be,
   input  logic [31:0]               reg_rdata
);
   timeunit 1ns;
   timeprecision 1ps;

   if (WORD_W != 32) begin : g_bad_word
      $error("pcit_target: word width must be 32");
   end

   pcit_state_e        state_q;
   logic [31:0]        addr_q;
   logic [3:0]         cmd_q;
   logic               sel_q, wr_q;
   logic [SPACE_W-1:0] space_q;
   logic               dec_hit, addr_bad, xfer, bus_idle;
   logic [SPACE_W-1:0] dec_space;

   pcit_decode #(.BAR_CNT(BAR_CNT), .IO_WIN_LOG2(IO_WIN_LOG2)) i_decode (
      .addr_hi (addr_q[31:IO_WIN_LOG2]),
      .addr_lo (addr_q[1:0]),
      .cmd_hi  (cmd_q[3:1]),
      .sel     (sel_q),
      .bar_base(bar_base),
      .hit     (dec_hit),
      .space   (dec_space)
   );

   assign xfer     = (state_q == ST_DATA) && !irdy_n;
   assign bus_idle = frame_n && irdy_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         cmd_q   <= '0;
         sel_q   <= 1'b0;
         wr_q    <= 1'b0;
         space_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (!frame_n) begin
               addr_q  <= ad_i;
               cmd_q   <= cbe_n;
               sel_q   <= idsel;
               state_q <= ST_DECODE;
            end
            ST_DECODE: if (dec_hit && !addr_bad) begin
               space_q <= dec_space;
               wr_q    <= cmd_q[0];
               state_q <= ST_DATA;
            end else begin
               state_q <= ST_WAIT;
            end
            ST_DATA: if (xfer) begin
               addr_q <= addr_q + 32'd4;
               if (frame_n) state_q <= ST_TURN;
            end
            ST_TURN: state_q <= bus_idle ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (bus_idle) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tgt_oe    = (state_q == ST_DATA) || (state_q == ST_TURN);
   assign trdy_n    = (state_q != ST_DATA);
   assign devsel_n  = (state_q != ST_DATA);
   assign stop_n    = 1'b1;
   assign ad_oe     = (state_q == ST_DATA) && !wr_q;
   assign ad_o      = ad_oe ? reg_rdata : '0;
   assign reg_addr  = addr_q;
   assign reg_space = space_q;
   assign reg_wr    = xfer && wr_q;
   assign reg_rd    = xfer && !wr_q;
   assign reg_wdata = ad_i;
   assign reg_be    = ~cbe_n;

   pcit_parity i_parity (
      .clk     (clk),
      .rst_n   (rst_n),
      .ad_i    (ad_i),
      .cbe_n   (cbe_n),
      .par_i   (par_i),
      .ad_o    (ad_o),
      .ad_oe   (ad_oe),
      .wr_xfer (reg_wr),
      .addr_chk(state_q == ST_DECODE),
      .addr_par(even_bit(addr_q, cmd_q)),
      .addr_bad(addr_bad),
      .par_o   (par_o),
      .par_oe  (par_oe),
      .perr_n  (perr_n),
      .serr_oe (serr_oe)
   );

   // R2: DEVSEL falls two cycles after an address phase
   p_claim_delay_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> !$past(frame_n, 2));
   // R5: back-to-back transfers step the word address by 4
   p_burst_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && $past(reg_wr || reg_rd)) |-> (reg_addr == $past(reg_addr) + 32'd4));
   // R7: the final transfer is followed by one cycle of driven-high handshake
   p_release_high_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && frame_n) |=> (tgt_oe && trdy_n && devsel_n));
   // R7: outputs are only floated after being driven high
   p_float_after_high_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_oe) |-> ($past(trdy_n) && $past(devsel_n)));
endmodule

// File: tb/test_pcit_target.sv
module test_pcit_target;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned BAR_CNT = 2;
   localparam int unsigned WIN     = 4;
   localparam int unsigned BASE_W  = 32 - WIN;
   localparam int unsigned SPW     = 2;
   localparam logic [BASE_W-1:0] BASE0 = 28'h0000_B00;
   localparam logic [BASE_W-1:0] BASE1 = 28'h0000_C10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] ad_i = '0, ad_o, reg_addr, reg_wdata, reg_rdata;
   logic [3:0]  cbe_n = 4'hF, reg_be;
   logic par_i = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
   logic ad_oe, par_o, par_oe, trdy_n, devsel_n, stop_n, tgt_oe, perr_n, serr_oe;
   logic reg_wr, reg_rd;
   logic [SPW-1:0] reg_space;
   logic [31:0] prev_ad = '0;
   logic [3:0]  prev_cbe = 4'hF;
   int n_cmp = 0, n_bad = 0;
   bit ended = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] rd_model(input logic [SPW-1:0] sp, input logic [31:0] a);
      return {8'(sp) * 8'h11, a[23:0] ^ 24'h5A3C96};
   endfunction

   assign reg_rdata = rd_model(reg_space, reg_addr);

   pcit_target #(.BAR_CNT(BAR_CNT), .IO_WIN_LOG2(WIN)) i_pcit_target (
      .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
      .cbe_n(cbe_n), .par_i(par_i), .par_o(par_o), .par_oe(par_oe),
      .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
      .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .tgt_oe(tgt_oe),
      .perr_n(perr_n), .serr_oe(serr_oe), .bar_base({BASE1, BASE0}),
      .reg_addr(reg_addr), .reg_space(reg_space), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // drive one bus cycle at the falling edge; PAR covers the previous cycle
   task automatic drive(input logic [31:0] ad, input logic [3:0] cbe, input logic fr,
                        input logic ir, input logic sel, input bit flip);
      @(negedge clk);
      par_i   = (^{prev_ad, prev_cbe}) ^ flip;
      ad_i    = ad;
      cbe_n   = cbe;
      frame_n = fr;
      irdy_n  = ir;
      idsel   = sel;
      prev_ad = ad;
      prev_cbe = cbe;
      #1;
   endtask

   // expected claim decision, written from R2/R3
   function automatic bit exp_hit(input logic [3:0] cmd, input logic [31:0] a, input bit sel,
                                  output logic [SPW-1:0] sp);
      sp = '0;
      if (cmd[3:1] == 3'b101 && sel && a[1:0] == 2'b00) return 1'b1;
      if (cmd[3:1] == 3'b001) begin
         if (a[31:WIN] == BASE0) begin sp = 2'd1; return 1'b1; end
         if (a[31:WIN] == BASE1) begin sp = 2'd2; return 1'b1; end
      end
      return 1'b0;
   endfunction

   task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                      input int n, input bit bad_ap, input int bad_dp, input bit waits);
      logic [31:0] dat [4];
      logic [3:0]  be [4];
      logic [SPW-1:0] sp;
      logic [31:0] exp_ad, prev_exp_ad;
      logic [3:0]  prev_rd_cbe;
      bit hit, claimed, is_wr, committed, wt, ir, fr, in_data, xf;
      bit bad1, bad2, prev_rd;
      int k, c;
      for (int i = 0; i < 4; i++) begin
         dat[i] = $urandom;
         be[i]  = 4'($urandom);
      end
      hit = exp_hit(cmd, addr, sel, sp);
      claimed = hit && !bad_ap;
      is_wr = cmd[0];
      bad1 = 0; bad2 = 0; prev_rd = 0; prev_exp_ad = '0; prev_rd_cbe = '0;
      committed = 0; k = 0;
      drive(addr, cmd, 1'b0, 1'b1, sel, 1'b0);
      check("R3 idle before claim tgt_oe", 32'(tgt_oe), 0);
      for (c = 1; c < 40; c++) begin
         if (claimed) begin
            wt = waits && !committed && ($urandom % 4 == 0);
            ir = wt;
            fr = wt ? 1'b0 : (k == n - 1);
            if (!ir && fr) committed = 1;
            drive(is_wr ? dat[k] : 32'h0, ~be[k], fr, ir, 1'b0, bad1 || (c == 1 && bad_ap));
         end else begin
            // R10: keep FRAME low and put a matching I/O write address on AD
            drive((c == 2) ? {BASE0, 4'h0} : 32'h0, (c == 2) ? 4'b0011 : 4'h0,
                  (c >= 4), 1'b0, 1'b0, bad1 || (c == 1 && bad_ap));
            ir = 1'b0;
         end
         in_data = claimed && (c >= 2);
         xf = in_data && !ir;
         check("R2/R3 tgt_oe", 32'(tgt_oe), 32'(in_data));
         if (in_data) begin
            check("R2 devsel_n", 32'(devsel_n), 0);
            check("R2 trdy_n", 32'(trdy_n), 0);
            check("R2 stop_n", 32'(stop_n), 1);
         end
         check("R4 reg_wr", 32'(reg_wr), 32'(xf && is_wr));
         check("R6 reg_rd", 32'(reg_rd), 32'(xf && !is_wr));
         if (xf) begin
            check("R5 reg_addr", reg_addr, addr + 32'(4 * k));
            check("R4 reg_space", 32'(reg_space), 32'(sp));
            if (is_wr) begin
               check("R4 reg_wdata", reg_wdata, dat[k]);
               check("R4 reg_be", 32'(reg_be), 32'(be[k]));
            end
         end
         check("R6 ad_oe", 32'(ad_oe), 32'(in_data && !is_wr));
         exp_ad = rd_model(sp, addr + 32'(4 * k));
         if (in_data && !is_wr) check("R6 ad_o", ad_o, exp_ad);
         check("R6 par_oe", 32'(par_oe), 32'(prev_rd));
         if (prev_rd) check("R6 par_o", 32'(par_o), 32'(^{prev_exp_ad, prev_rd_cbe}));
         check("R9 serr_oe", 32'(serr_oe), 32'(c == 2 && bad_ap));
         check("R8 perr_n", 32'(perr_n), 32'(!bad2));
         bad2 = bad1;
         bad1 = xf && is_wr && (k == bad_dp);
         prev_rd = in_data && !is_wr;
         prev_exp_ad = exp_ad;
         prev_rd_cbe = ~be[k];
         if (claimed && xf) begin
            if (k == n - 1) break;
            k++;
         end
         if (!claimed && c == 5) break;
      end
      // first cycle after the last transfer
      drive(32'h0, 4'hF, 1'b1, 1'b1, 1'b0, bad1);
      check("R7 tgt_oe held", 32'(tgt_oe), 32'(claimed));
      if (claimed) begin
         check("R7 trdy_n high", 32'(trdy_n), 1);
         check("R7 devsel_n high", 32'(devsel_n), 1);
      end
      check("R6 ad_oe released", 32'(ad_oe), 0);
      check("R6 par_oe tail", 32'(par_oe), 32'(prev_rd));
      if (prev_rd) check("R6 par_o tail", 32'(par_o), 32'(^{prev_exp_ad, prev_rd_cbe}));
      check("R8 perr_n tail", 32'(perr_n), 32'(!bad2));
      bad2 = bad1; bad1 = 0;
      drive(32'h0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0);
      check("R7 tgt_oe floated", 32'(tgt_oe), 0);
      check("R6 par_oe off", 32'(par_oe), 0);
      check("R8 perr_n late", 32'(perr_n), 32'(!bad2));
      drive(32'h0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0);
      check("R8 perr_n clear", 32'(perr_n), 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin : main
      logic [3:0] cmd;
      logic [31:0] addr;
      int n, kind;
      bit sel;
      void'($urandom(32'd20931));
      repeat (3) @(negedge clk);
      #1;
      check("R1 tgt_oe in reset", 32'(tgt_oe), 0);
      check("R1 ad_oe in reset", 32'(ad_oe), 0);
      check("R1 perr_n in reset", 32'(perr_n), 1);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1 par_oe after reset", 32'(par_oe), 0);
      check("R1 serr_oe after reset", 32'(serr_oe), 0);
      check("R1 strobes after reset", 32'({reg_wr, reg_rd}), 0);

      // directed corners
      txn(4'b0011, {BASE0, 4'h0}, 0, 1, 0, -1, 0);   // R4 single write window 0
      txn(4'b0010, {BASE1, 4'h0}, 0, 4, 0, -1, 1);   // R5 R6 read burst with waits
      txn(4'b1011, 32'h0000_0010, 1, 2, 0, -1, 0);   // R2 config write
      txn(4'b1010, 32'h0000_0010, 0, 1, 0, -1, 0);   // R3 config without select
      txn(4'b1010, 32'h0000_0011, 1, 1, 0, -1, 0);   // R3 type-1 config
      txn(4'b0011, 32'h0000_D000, 0, 1, 0, -1, 0);   // R3 R10 out of window
      txn(4'b0110, {BASE0, 4'h0}, 0, 1, 0, -1, 0);   // R3 memory command
      txn(4'b0011, {BASE0, 4'h4}, 0, 2, 1, -1, 0);   // R9 address parity
      txn(4'b0011, {BASE1, 4'h0}, 0, 3, 0, 1, 0);    // R8 data parity mid burst
      txn(4'b0011, {BASE0, 4'h0}, 0, 2, 0, 1, 0);    // R8 data parity on last phase

      for (int t = 0; t < 80; t++) begin
         kind = int'($urandom % 8);
         n = 1 + int'($urandom % 4);
         sel = 1'b0;
         addr = {BASE0, 2'($urandom % (5 - n)), 2'b00};
         case (kind)
            0, 1: cmd = {3'b001, kind[0]};
            2, 3: begin cmd = {3'b001, kind[0]}; addr = {BASE1, addr[3:0]}; end
            4, 5: begin cmd = {3'b101, kind[0]}; sel = 1'b1; addr = {24'h0, 6'($urandom), 2'b00}; end
            6: begin cmd = 4'b1010; addr = {24'h0, 6'($urandom), 2'b00}; end
            default: begin cmd = ($urandom % 2 == 0) ? 4'b0111 : 4'b0010; addr = 32'h0001_0000 | addr; end
         endcase
         txn(cmd, addr, sel, n, ($urandom % 10 == 0),
             ($urandom % 5 == 0) ? int'($urandom % n) : -1, 1'b1);
      end
      finish_run();
   end
endmodule